// File: doc/BRIEF.md
# Accumulator Execution Core with Banked File Memory

This block is a compact 8-bit processor core built around one working register (W) and a 4096-byte file memory that is reached through an 8-bit in-instruction offset. The offset is widened to 12 bits in one of two ways. The core can use a 4-bit bank register. It can also use a fixed window that covers the lowest 128 bytes and the highest 128 bytes of the file space. The core fetches 16-bit instruction words from a word-addressed program memory. Each instruction cycle takes four clocks.

The instruction subset covers the following operations:
- loading a literal into W
- loading a literal into the bank register
- storing W to a file location
- moving a file location
- adding and subtracting W against a file location
- incrementing and decrementing a file location
- a two-word memory-to-memory copy
- a two-word absolute jump

Each single-operand or two-operand ALU instruction has a destination bit that sends the result either to W or back to the file location. Arithmetic wraps modulo 256 and produces no flags. Any encoding the core does not recognise executes as a no-op.

Both memories are expected to read combinationally. The core writes the file memory at the last clock of an instruction cycle. An instruction-cycle strobe and debug copies of the program counter and of W let a surrounding system or bench follow execution.

Top module: `acc8_core`

## Requirements
- R1: When reset is released, the program counter is 0, W is 0, the bank register is 0, and the first fetch reads program word 0.
- R2: An instruction cycle is exactly four clocks. `icyc_o` is high only in the fourth clock. The program counter and W change only at the clock edge that ends an instruction cycle.
- R3: The program counter is a byte address and is always even. `imem_waddr` equals the program counter divided by 2. A single-word instruction takes one instruction cycle and advances the program counter by 2.
- R4: Word `0x0E` in bits 15:8 with literal k in bits 7:0 loads k into W.
- R5: Word `0110111a ffffffff` stores W to the file memory. The target address depends on a:
  - a=1: the target is {bank, f}.
  - a=0 and f < 0x80: the target is 0x000+f.
  - a=0 and f >= 0x80: the target is 0xF00+f.
- R6: Word `000000010000kkkk` loads k into the bank register. This selects the upper four address bits for later a=1 accesses.
- R7: Add (`001001da f`) computes file+W, and subtract (`010111da f`) computes file−W, both modulo 256. d=0 writes the result to W and leaves the file location unchanged. d=1 writes the result to the file location and leaves W unchanged.
- R8: Move (`010100da f`), increment (`001010da f`) and decrement (`000001da f`) produce file, file+1 and file−1 modulo 256. The result goes to the destination selected by d, as in R7.
- R9: Copy spans two words, `1100 s[11:0]` followed by `1111 t[11:0]`. It writes the byte at absolute address s to absolute address t at the end of the second instruction cycle and advances the program counter by 4.
- R10: Jump spans two words, `11101111 k[7:0]` followed by `1111 k[19:8]`. After two instruction cycles the program counter holds k×2, and the next fetch is from word k.
- R11: Unrecognised words, including a `1111xxxx xxxxxxxx` word that is reached on its own, perform no file write and leave W unchanged. They advance the program counter by 2.
- R12: `dmem_we` is asserted only while `icyc_o` is high, so there is at most one file write per instruction cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_waddr | output | PC_W-1 | Program memory word address |
| imem_rdata | input | 16 | Instruction word read combinationally at `imem_waddr` |
| dmem_addr | output | 12 | File memory address |
| dmem_rdata | input | 8 | File byte read combinationally at `dmem_addr` |
| dmem_we | output | 1 | File memory write enable |
| dmem_wdata | output | 8 | File memory write data |
| icyc_o | output | 1 | High in the last clock of each instruction cycle |
| dbg_pc | output | PC_W | Current program counter (byte address) |
| dbg_w | output | 8 | Current W register |

## Verification
The bench builds the core with its default 21-bit program counter. It backs the core with a 1024-word program store and a full 4096-byte file store, so every bank and both halves of the fixed window can be reached. The full file space lets the bench confirm that banked and window stores land on distinct addresses. The program store is large enough to reach a jump target at word 0x104. Every ALU operation is swept, for both destination settings, over a grid of 16×16 operand pairs. The grid includes 0x00 and 0xFF, so every wrap at 0 and at 255 is covered, and the expected byte is computed arithmetically. Directed short programs cover the copy, the jump, the bank register and stray operand words. For each of these, the program counter and the number of file writes are compared after each instruction cycle.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
    localparam int IW   = 16;
    localparam int DW   = 8;
    localparam int FAW  = 12;
    localparam int BKW  = 4;

    typedef enum logic [3:0] {
        OP_NOP, OP_LDLIT, OP_STW, OP_MOVE, OP_ADD, OP_SUB,
        OP_INC, OP_DEC, OP_LDBANK, OP_COPY, OP_JUMP
    } op_e;

    typedef enum logic [1:0] {
        PEND_NONE, PEND_COPY, PEND_JUMP
    } pend_e;
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [IW-1:0]  ir,
    output op_e            op,
    output logic           dst_file,
    output logic           banked,
    output logic [DW-1:0]  offs,
    output logic [BKW-1:0] bank_lit
);
    always_comb begin
        op       = OP_NOP;
        dst_file = ir[9];
        banked   = ir[8];
        offs     = ir[7:0];
        bank_lit = ir[3:0];
        if      (ir[15:10] == 6'b010100)      op = OP_MOVE;
        else if (ir[15:10] == 6'b001001)      op = OP_ADD;
        else if (ir[15:10] == 6'b010111)      op = OP_SUB;
        else if (ir[15:10] == 6'b001010)      op = OP_INC;
        else if (ir[15:10] == 6'b000001)      op = OP_DEC;
        else if (ir[15:9]  == 7'b0110111)     op = OP_STW;
        else if (ir[15:8]  == 8'h0E)          op = OP_LDLIT;
        else if (ir[15:4]  == 12'h010)        op = OP_LDBANK;
        else if (ir[15:12] == 4'hC)           op = OP_COPY;
        else if (ir[15:8]  == 8'hEF)          op = OP_JUMP;
    end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] wreg,
    input  logic [DW-1:0] fval,
    output logic [DW-1:0] res
);
    always_comb begin
        case (op)
            OP_ADD:  res = fval + wreg;
            OP_SUB:  res = fval - wreg;
            OP_INC:  res = fval + DW'(1);
            OP_DEC:  res = fval - DW'(1);
            default: res = fval;
        endcase
    end
endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-2:0]   imem_waddr,
    input  logic [IW-1:0]     imem_rdata,
    output logic [FAW-1:0]    dmem_addr,
    input  logic [DW-1:0]     dmem_rdata,
    output logic              dmem_we,
    output logic [DW-1:0]     dmem_wdata,
    output logic              icyc_o,
    output logic [PC_W-1:0]   dbg_pc,
    output logic [DW-1:0]     dbg_w
);
    localparam int PH_W      = 2;
    localparam logic [PH_W-1:0] PH_FETCH = 2'd0;
    localparam logic [PH_W-1:0] PH_READ  = 2'd1;
    localparam logic [PH_W-1:0] PH_LAST  = 2'd3;
    localparam int HI_W      = FAW - DW;

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [PC_W-1:0] pc;
        logic [DW-1:0]   w;
        logic [BKW-1:0]  bank;
        logic [IW-1:0]   ir;
        logic [DW-1:0]   opnd;
        logic [DW-1:0]   hold;
        pend_e           pend;
    } state_t;

    state_t s_q, s_d;

    op_e            op;
    logic           dst_file, banked;
    logic [DW-1:0]  offs, alu_res;
    logic [BKW-1:0] bank_lit;
    logic [FAW-1:0] file_addr;
    logic           we_d;
    logic [DW-1:0]  wdata_d;

    acc8_decode u_dec (
        .ir(s_q.ir), .op(op), .dst_file(dst_file), .banked(banked),
        .offs(offs), .bank_lit(bank_lit)
    );

    acc8_alu u_alu (
        .op(op), .wreg(s_q.w), .fval(s_q.opnd), .res(alu_res)
    );

    // banked: bank register on top; otherwise bit 7 picks low or high window
    always_comb begin
        if (banked) file_addr = {s_q.bank, offs};
        else        file_addr = {{HI_W{offs[7]}}, offs};
        if (s_q.pend == PEND_COPY || (s_q.pend == PEND_NONE && op == OP_COPY))
            dmem_addr = s_q.ir[FAW-1:0];
        else
            dmem_addr = file_addr;
    end

    always_comb begin
        s_d       = s_q;
        we_d      = 1'b0;
        wdata_d   = s_q.w;
        s_d.phase = s_q.phase + PH_W'(1);
        case (s_q.phase)
            PH_FETCH: s_d.ir   = imem_rdata;
            PH_READ:  s_d.opnd = dmem_rdata;
            PH_LAST: begin
                s_d.pc   = s_q.pc + PC_W'(2);
                s_d.pend = PEND_NONE;
                if (s_q.pend == PEND_COPY) begin
                    we_d    = 1'b1;
                    wdata_d = s_q.hold;
                end else if (s_q.pend == PEND_JUMP) begin
                    s_d.pc = PC_W'({s_q.ir[FAW-1:0], s_q.hold, 1'b0});
                end else begin
                    case (op)
                        OP_LDLIT:  s_d.w    = offs;
                        OP_LDBANK: s_d.bank = bank_lit;
                        OP_STW:    we_d     = 1'b1;
                        OP_MOVE, OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
                            if (dst_file) begin
                                we_d    = 1'b1;
                                wdata_d = alu_res;
                            end else begin
                                s_d.w = alu_res;
                            end
                        end
                        OP_COPY: begin
                            s_d.hold = s_q.opnd;
                            s_d.pend = PEND_COPY;
                        end
                        OP_JUMP: begin
                            s_d.hold = offs;
                            s_d.pend = PEND_JUMP;
                        end
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: '0, pc: '0, w: '0, bank: '0, ir: '0,
                     opnd: '0, hold: '0, pend: PEND_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_waddr = s_q.pc[PC_W-1:1];
    assign dmem_we    = we_d;
    assign dmem_wdata = wdata_d;
    assign icyc_o     = (s_q.phase == PH_LAST);
    assign dbg_pc     = s_q.pc;
    assign dbg_w      = s_q.w;
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
    parameter int PC_W = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            icyc_o,
    input logic            dmem_we,
    input logic [PC_W-1:0] dbg_pc,
    input logic [7:0]      dbg_w
);
    assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        icyc_o |=> !icyc_o);
    assert_strobe_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        icyc_o |-> ##4 icyc_o);
    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !icyc_o |=> $stable(dbg_pc));
    assert_w_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !icyc_o |=> $stable(dbg_w));
    assert_pc_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_pc[0] == 1'b0);
    assert_write_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> icyc_o);
endmodule

bind acc8_core acc8_core_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .icyc_o(icyc_o), .dmem_we(dmem_we),
    .dbg_pc(dbg_pc), .dbg_w(dbg_w)
);

// File: tb/acc8_core_tb_top.sv
`timescale 1ns/1ps
module acc8_core_tb_top;
    localparam int PC_W = 21;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-2:0] imem_waddr;
    logic [15:0]     imem_rdata;
    logic [11:0]     dmem_addr;
    logic [7:0]      dmem_rdata;
    logic            dmem_we;
    logic [7:0]      dmem_wdata;
    logic            icyc_o;
    logic [PC_W-1:0] dbg_pc;
    logic [7:0]      dbg_w;

    logic [15:0] imem [0:1023];
    logic [7:0]  dmem [0:4095];

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int bad_wr = 0;

    always #4 clk = ~clk;

    acc8_core #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .imem_waddr(imem_waddr),
        .imem_rdata(imem_rdata), .dmem_addr(dmem_addr),
        .dmem_rdata(dmem_rdata), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .icyc_o(icyc_o),
        .dbg_pc(dbg_pc), .dbg_w(dbg_w)
    );

    assign imem_rdata = imem[imem_waddr[9:0]];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (rst_n && dmem_we) begin
            dmem[dmem_addr] <= dmem_wdata;
            wr_cnt <= wr_cnt + 1;
            if (!icyc_o) bad_wr <= bad_wr + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) imem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr_cnt = 0;
    endtask

    task automatic run_cycles(input int n);
        repeat (4 * n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] expect_alu(input logic [5:0] opc,
                                               input logic [7:0] w,
                                               input logic [7:0] f);
        case (opc)
            6'b001001: return f + w;
            6'b010111: return f - w;
            6'b001010: return f + 8'd1;
            6'b000001: return f - 8'd1;
            default:   return f;
        endcase
    endfunction

    task automatic alu_case(input logic [5:0] opc, input logic d,
                            input logic [7:0] w, input logic [7:0] f,
                            input string req);
        logic [7:0] e;
        clear_prog();
        imem[0] = {8'h0E, f};
        imem[1] = 16'h6E59;
        imem[2] = {8'h0E, w};
        imem[3] = {opc, d, 1'b0, 8'h59};
        dmem[12'h059] = 8'h00;
        do_reset();
        run_cycles(4);
        e = expect_alu(opc, w, f);
        if (d) begin
            chk(req, dmem[12'h059], e);
            chk(req, dbg_w, w);
        end else begin
            chk(req, dbg_w, e);
            chk(req, dmem[12'h059], f);
        end
        chk("R3", dbg_pc, 8);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [5:0] ops [5];
        ops[0] = 6'b010100; ops[1] = 6'b001001; ops[2] = 6'b010111;
        ops[3] = 6'b001010; ops[4] = 6'b000001;
        for (int i = 0; i < 1024; i++) imem[i] = 16'h0000;
        for (int i = 0; i < 4096; i++) dmem[i] = 8'h00;

        // R1: reset state
        do_reset();
        chk("R1", dbg_pc, 0);
        chk("R1", dbg_w, 0);
        chk("R1", imem_waddr, 0);

        // R2/R3: four clocks per cycle, PC steps by 2 on no-ops
        begin
            int strobes = 0;
            for (int c = 0; c < 40; c++) begin
                @(posedge clk);
                #1;
                if (icyc_o) strobes++;
            end
            chk("R2", strobes, 10);
            @(negedge clk);
            chk("R3", dbg_pc, 20);
            chk("R3", imem_waddr, 10);
        end

        // R7: worked example values
        alu_case(6'b001001, 1'b0, 8'h1D, 8'hBA, "R7");
        alu_case(6'b010111, 1'b1, 8'h1D, 8'hBA, "R7");
        chk("R7", dmem[12'h059], 8'h9D);

        // R7/R8: sweep every ALU op, both destinations, 16x16 operands
        for (int o = 0; o < 5; o++)
            for (int d = 0; d < 2; d++)
                for (int wi = 0; wi < 16; wi++)
                    for (int fi = 0; fi < 16; fi++)
                        alu_case(ops[o], d[0], 8'(wi * 17), 8'(fi * 17),
                                 (o == 1 || o == 2) ? "R7" : "R8");

        // R4/R5/R6/R12: literal, store addressing, bank register
        clear_prog();
        for (int i = 0; i < 4096; i++) dmem[i] = 8'h00;
        imem[0] = 16'h0E2A;   // W = 0x2A
        imem[1] = 16'h6F71;   // banked, bank 0 -> 0x071
        imem[2] = 16'h6E70;   // window low -> 0x070
        imem[3] = 16'h0102;   // bank = 2
        imem[4] = 16'h6F70;   // -> 0x270
        imem[5] = 16'h6E90;   // window high -> 0xF90
        imem[6] = 16'h6F90;   // -> 0x290
        do_reset();
        run_cycles(1);
        chk("R4", dbg_w, 8'h2A);
        run_cycles(6);
        chk("R1", dmem[12'h071], 8'h2A);
        chk("R5", dmem[12'h070], 8'h2A);
        chk("R6", dmem[12'h270], 8'h2A);
        chk("R5", dmem[12'hF90], 8'h2A);
        chk("R6", dmem[12'h290], 8'h2A);
        chk("R5", dmem[12'h170], 8'h00);
        chk("R5", dmem[12'h090], 8'h00);
        chk("R12", wr_cnt, 5);
        chk("R3", dbg_pc, 14);

        // R9: two-word copy
        clear_prog();
        dmem[12'h1A0] = 8'h5C;
        dmem[12'h23F] = 8'h00;
        imem[0] = 16'hC1A0;
        imem[1] = 16'hF23F;
        do_reset();
        run_cycles(1);
        chk("R9", dmem[12'h23F], 8'h00);
        chk("R9", dbg_pc, 2);
        run_cycles(1);
        chk("R9", dmem[12'h23F], 8'h5C);
        chk("R9", dbg_pc, 4);
        chk("R9", wr_cnt, 1);

        // R10: two-word jump to byte 0x208 (word 0x104)
        clear_prog();
        imem[0] = 16'hEF04;
        imem[1] = 16'hF001;
        imem[2] = 16'h0E11;
        imem[12'h104] = 16'h0E77;
        do_reset();
        run_cycles(1);
        chk("R10", dbg_pc, 2);
        run_cycles(1);
        chk("R10", dbg_pc, 12'h208);
        chk("R10", imem_waddr, 12'h104);
        run_cycles(1);
        chk("R10", dbg_w, 8'h77);
        chk("R10", dbg_pc, 12'h20A);
        imem[12'h104] = 16'h0000;

        // R11: unknown and stray second words
        clear_prog();
        dmem[12'h123] = 8'hAB;
        imem[0] = 16'h0E33;
        imem[1] = 16'hF123;
        imem[2] = 16'h1234;
        imem[3] = 16'hFFFF;
        imem[4] = 16'h0000;
        do_reset();
        run_cycles(5);
        chk("R11", dbg_w, 8'h33);
        chk("R11", dbg_pc, 10);
        chk("R11", dmem[12'h123], 8'hAB);
        chk("R11", wr_cnt, 0);

        // R12: writes only in the strobe clock
        chk("R12", bad_wr, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule